// File: doc/BRIEF.md
# Comma Word-Alignment 1:4 Demux

This block sits behind a line decoder that delivers one decoded character per clock, each with a data byte, a control-character flag and a code-violation flag. It gathers four characters into one 32-bit word and delivers them together with a 4-bit control vector, a 4-bit violation vector and a one-cycle word strobe. Later stages such as multi-lane deskew need every word boundary to be stable. Lane alignment may begin only once word alignment is complete.

The block chooses where each word starts by watching for the synchronizing comma character. While it is seeking alignment, a comma in any byte position restarts the word so that the comma fills the leading byte lane. The partly built word is dropped, and the status output reports alignment. Once aligned, the boundary stays where it is, even when a comma turns up elsewhere in a word. A 0-to-1 edge on the realign input re-arms the search. A disable input freezes the boundary entirely.

Top module: `comma_word_packer`

## Requirements
- R1: Four accepted characters form one word. The first accepted character occupies `out_data[31:24]` and the fourth occupies `out_data[7:0]`. In `out_k` and `out_cv`, bit 3 belongs to the first character and bit 0 to the fourth. `out_valid` is high for exactly one cycle, in the cycle after the fourth character is accepted.
- R2: A comma is a character with `in_k`=1 and `in_byte`=8'hBC. While the block is seeking alignment (after reset, or after a realign edge) and `align_dis`=0, a comma in any lane starts a new word with the comma in `out_data[31:24]`. The characters collected before it are dropped and no `out_valid` is produced for them. This holds even when the comma arrives in the last lane.
- R3: `aligned` goes to 1 in the cycle after the comma that fixes the boundary, and it rises at no other time.
- R4: While aligned with no realign pending, a comma in a non-leading lane is packed as ordinary data and the boundary does not move.
- R5: A 0-to-1 transition of `realign_req` clears `aligned` in the next cycle and makes the next comma realign the boundary. Holding `realign_req` at 1 does not arm the search again.
- R6: While `align_dis`=1 the boundary never moves and `aligned` does not rise. A search armed during that time stays pending until `align_dis` returns to 0.
- R7: When a realign edge and a comma arrive in the same cycle, that comma realigns the boundary.
- R8: Cycles with `in_valid`=0 leave the partial word, the lane position and the outputs unchanged.
- R9: After reset, `aligned`=0, `out_valid`=0, `out_data`, `out_k` and `out_cv` are 0, and the block is seeking alignment.
- R10: Each character's violation flag and control flag travel in the lane of `out_cv`/`out_k` that matches that character's data lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is present this cycle |
| in_byte | input | 8 | Decoded data byte |
| in_k | input | 1 | Character is a control character |
| in_cv | input | 1 | Decoder flagged a code violation |
| realign_req | input | 1 | A rising edge re-arms the comma search |
| align_dis | input | 1 | 1 freezes the word boundary |
| out_data | output | 32 | Packed word; the first character is in the top byte |
| out_k | output | 4 | Control flags per lane; bit 3 is the first character |
| out_cv | output | 4 | Violation flags per lane; bit 3 is the first character |
| out_valid | output | 1 | One-cycle strobe for a new word |
| aligned | output | 1 | Word alignment achieved |

## Verification
Two collisions can happen in a single cycle. The first is a realign edge arriving together with a comma. The bench raises `realign_req` in the same cycle as a comma in lane 2 and expects the following word to begin with that comma, with `aligned` staying high. The second is a boundary move landing on the cycle that would otherwise complete a word. The bench sends a comma as the fourth character of a word while the search is armed and expects no strobe for the dropped bytes. The next strobe must carry the comma in the top lane. A scoreboard model, written from the requirements, predicts every word and the `aligned` level after each cycle.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    // Action that the control path asks of the lane packer each cycle
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,   // no character accepted
        ACT_FILL    = 2'd1,   // store character in the selected lane
        ACT_CLOSE   = 2'd2,   // character completes the word
        ACT_RESTART = 2'd3    // comma restarts the word in lane 0
    } pack_act_e;

endpackage

// File: rtl/cwp_comma_match.sv
module cwp_comma_match #(
    parameter int              BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC
) (
    input  logic              valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              k_in,
    output logic              hit
);
    always_comb begin
        hit = valid && k_in && (byte_in == COMMA_CODE);
    end
endmodule

// File: rtl/cwp_edge_rise.sv
module cwp_edge_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
        rise   = level && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cwp_lane_packer.sv
module cwp_lane_packer
    import cwp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(LANES),
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pack_act_e         act,
    input  logic [IDX_W-1:0]  lane_sel,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              k_in,
    input  logic              cv_in,
    output logic [WORD_W-1:0] word_data,
    output logic [LANES-1:0]  word_k,
    output logic [LANES-1:0]  word_cv,
    output logic              word_valid
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              k;
        logic              cv;
    } lane_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  k;
        logic [LANES-1:0]  cv;
        logic              valid;
    } out_t;

    lane_t             in_lane;
    logic [WORD_W-1:0] asm_data;
    logic [LANES-1:0]  asm_k;
    logic [LANES-1:0]  asm_cv;

    always_comb begin
        in_lane = '{data: byte_in, k: k_in, cv: cv_in};
    end

    // Storage for every lane but the last; lane 0 maps to the top byte
    for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
        lane_t l_d, l_q;

        always_comb begin
            l_d = l_q;
            unique case (act)
                ACT_RESTART: l_d = (i == 0) ? in_lane : '0;
                ACT_FILL:    if (lane_sel == IDX_W'(i)) l_d = in_lane;
                ACT_CLOSE:   l_d = '0;
                default:     l_d = l_q;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) l_q <= '0;
            else        l_q <= l_d;
        end

        assign asm_data[(LANES-1-i)*BYTE_W +: BYTE_W] = l_q.data;
        assign asm_k[LANES-1-i]  = l_q.k;
        assign asm_cv[LANES-1-i] = l_q.cv;
    end

    // The closing character goes straight into the bottom lane
    assign asm_data[BYTE_W-1:0] = byte_in;
    assign asm_k[0]  = k_in;
    assign asm_cv[0] = cv_in;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = 1'b0;
        if (act == ACT_CLOSE) begin
            o_d.data  = asm_data;
            o_d.k     = asm_k;
            o_d.cv    = asm_cv;
            o_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign word_data  = o_q.data;
    assign word_k     = o_q.k;
    assign word_cv    = o_q.cv;
    assign word_valid = o_q.valid;
endmodule

// File: rtl/comma_word_packer.sv
module comma_word_packer
    import cwp_pkg::*;
#(
    parameter int              LANES      = 4,
    parameter int              BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC,
    localparam int IDX_W  = $clog2(LANES),
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_k,
    input  logic              in_cv,
    input  logic              realign_req,
    input  logic              align_dis,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_k,
    output logic [LANES-1:0]  out_cv,
    output logic              out_valid,
    output logic              aligned
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;      // lane for the next character
        logic             arm;      // comma search pending
        logic             aligned;  // boundary fixed by a comma
    } ctl_t;

    logic      comma_hit;
    logic      req_rise;
    pack_act_e act;
    ctl_t      c_d, c_q;
    logic      arm_now;

    cwp_comma_match #(
        .BYTE_W     (BYTE_W),
        .COMMA_CODE (COMMA_CODE)
    ) u_match (
        .valid   (in_valid),
        .byte_in (in_byte),
        .k_in    (in_k),
        .hit     (comma_hit)
    );

    cwp_edge_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (realign_req),
        .rise  (req_rise)
    );

    always_comb begin
        c_d     = c_q;
        act     = ACT_IDLE;
        arm_now = c_q.arm || req_rise;
        if (req_rise) c_d.aligned = 1'b0;
        if (in_valid) begin
            if (comma_hit && arm_now && !align_dis) begin
                act         = ACT_RESTART;
                c_d.idx     = IDX_W'(1);
                c_d.aligned = 1'b1;
                arm_now     = 1'b0;
            end else if (c_q.idx == LAST_IDX) begin
                act     = ACT_CLOSE;
                c_d.idx = '0;
            end else begin
                act     = ACT_FILL;
                c_d.idx = c_q.idx + IDX_W'(1);
            end
        end
        c_d.arm = arm_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{idx: '0, arm: 1'b1, aligned: 1'b0};
        else        c_q <= c_d;
    end

    cwp_lane_packer #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .lane_sel   (c_q.idx),
        .byte_in    (in_byte),
        .k_in       (in_k),
        .cv_in      (in_cv),
        .word_data  (out_data),
        .word_k     (out_k),
        .word_cv    (out_cv),
        .word_valid (out_valid)
    );

    assign aligned = c_q.aligned;
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
    parameter int              LANES      = 4,
    parameter int              BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [BYTE_W-1:0]       in_byte,
    input logic                    in_k,
    input logic                    in_cv,
    input logic                    realign_req,
    input logic                    align_dis,
    input logic [LANES*BYTE_W-1:0] out_data,
    input logic [LANES-1:0]        out_k,
    input logic [LANES-1:0]        out_cv,
    input logic                    out_valid,
    input logic                    aligned
);
    logic usable_comma;
    assign usable_comma = in_valid && in_k && (in_byte == COMMA_CODE) && !align_dis;

    // R3: alignment rises only right after a usable comma
    a_r3_rise_needs_comma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(usable_comma));

    // R6: with alignment disabled an unaligned block stays unaligned
    a_r6_disabled_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (align_dis && !aligned) |=> !aligned);

    // R5: a realign edge without a usable comma drops the status
    a_r5_edge_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(realign_req) && !usable_comma) |=> !aligned);

    // R1: a word needs several characters, so strobes never touch
    a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: a strobe always follows an accepted character
    a_r8_strobe_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

bind comma_word_packer cwp_checker #(
    .LANES      (LANES),
    .BYTE_W     (BYTE_W),
    .COMMA_CODE (COMMA_CODE)
) u_chk (.*);

// File: tb/comma_word_packer_tb.sv
`timescale 1ns/1ps
module comma_word_packer_tb;
    localparam real        PERIOD = 20.0;
    localparam logic [7:0] COMMA  = 8'hBC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_k = 1'b0;
    logic        in_cv = 1'b0;
    logic        realign_req = 1'b0;
    logic        align_dis = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_k;
    logic [3:0]  out_cv;
    logic        out_valid;
    logic        aligned;

    always #(PERIOD/2) clk = ~clk;

    comma_word_packer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_k(in_k), .in_cv(in_cv), .realign_req(realign_req),
        .align_dis(align_dis), .out_data(out_data), .out_k(out_k),
        .out_cv(out_cv), .out_valid(out_valid), .aligned(aligned)
    );

    typedef struct {
        logic [31:0] data;
        logic [3:0]  k;
        logic [3:0]  cv;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference state from the requirements
    int          m_idx = 0;
    bit          m_arm = 1;
    bit          m_aligned = 0;
    bit          m_prev = 0;
    logic [31:0] m_data;
    logic [3:0]  m_k;
    logic [3:0]  m_cv;
    bit          req_lvl = 0;
    bit          dis_lvl = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit k,
                        input bit cv, input string tag);
        bit rise, arm, hit;
        exp_t e;
        in_valid = v; in_byte = b; in_k = k; in_cv = cv;
        realign_req = req_lvl; align_dis = dis_lvl;
        rise   = req_lvl && !m_prev;
        m_prev = req_lvl;
        arm    = m_arm || rise;
        if (rise) m_aligned = 0;
        hit = v && k && (b == COMMA);
        if (v) begin
            if (hit && arm && !dis_lvl) begin
                m_data = '0; m_k = '0; m_cv = '0;
                m_data[31:24] = b; m_k[3] = k; m_cv[3] = cv;
                m_idx = 1; m_aligned = 1; arm = 0;
            end else begin
                m_data[(3-m_idx)*8 +: 8] = b;
                m_k[3-m_idx]  = k;
                m_cv[3-m_idx] = cv;
                if (m_idx == 3) begin
                    e.data = m_data; e.k = m_k; e.cv = m_cv; e.tag = tag;
                    exp_q.push_back(e);
                    m_idx = 0;
                end else begin
                    m_idx++;
                end
            end
        end
        m_arm = arm;
        @(posedge clk);
        @(negedge clk);
        check(aligned === m_aligned, tag, "aligned", 32'(aligned), 32'(m_aligned));
    endtask

    task automatic dat(input logic [7:0] b, input string tag);
        step(1, b, 0, 0, tag);
    endtask

    task automatic com(input string tag);
        step(1, COMMA, 1, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 8'h00, 0, 0, tag);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected word", out_data, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data === e.data, e.tag, "data", out_data, e.data);
                check(out_k === e.k, e.tag, "k vector", 32'(out_k), 32'(e.k));
                check(out_cv === e.cv, e.tag, "cv vector", 32'(out_cv), 32'(e.cv));
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(aligned === 1'b0, "R9", "aligned", 32'(aligned), 32'h0);
        check(out_valid === 1'b0, "R9", "out_valid", 32'(out_valid), 32'h0);
        check(out_data === 32'h0, "R9", "out_data", out_data, 32'h0);
        check({out_k, out_cv} === 8'h0, "R9", "k/cv", 32'({out_k, out_cv}), 32'h0);

        // R2/R3: comma in lane 2 after reset restarts the word
        step(1, 8'h11, 0, 1, "R2"); dat(8'h22, "R2"); com("R3");
        dat(8'h33, "R2"); dat(8'h44, "R2"); dat(8'h55, "R2");

        // R1/R10: lane order and per-lane flags
        step(1, 8'hA1, 0, 0, "R1"); step(1, 8'h1C, 1, 0, "R10");
        step(1, 8'hA3, 0, 1, "R10"); step(1, 8'hA4, 0, 1, "R10");
        dat(8'hB1, "R1"); dat(8'hB2, "R1"); dat(8'hB3, "R1"); dat(8'hB4, "R1");

        // R8: gaps hold the partial word
        dat(8'h01, "R8"); idle("R8"); dat(8'h02, "R8"); idle("R8"); idle("R8");
        check(out_valid === 1'b0, "R8", "no strobe in gap", 32'(out_valid), 32'h0);
        dat(8'h03, "R8"); idle("R8"); dat(8'h04, "R8");

        // R4: aligned, comma in lane 2 is plain data
        dat(8'h10, "R4"); dat(8'h20, "R4"); com("R4"); dat(8'h30, "R4");

        // R5: realign edge, comma in lane 1 moves the boundary
        req_lvl = 1; idle("R5");
        dat(8'h40, "R5"); com("R5"); dat(8'h50, "R5"); dat(8'h60, "R5"); dat(8'h70, "R5");
        // R5: level held high does not re-arm
        dat(8'h81, "R5"); com("R5"); dat(8'h82, "R5"); dat(8'h83, "R5");
        req_lvl = 0; idle("R5");

        // R6: disabled, an armed search does not move the boundary
        dis_lvl = 1; req_lvl = 1; idle("R6");
        dat(8'h90, "R6"); com("R6"); dat(8'h91, "R6"); dat(8'h92, "R6");
        req_lvl = 0; idle("R6");
        dis_lvl = 0;
        dat(8'h93, "R6"); com("R6"); dat(8'h94, "R6"); dat(8'h95, "R6"); dat(8'h96, "R6");

        // R7: realign edge and comma in the same cycle
        dat(8'h01, "R7"); dat(8'h02, "R7");
        req_lvl = 1; com("R7");
        req_lvl = 0;
        dat(8'h03, "R7"); dat(8'h04, "R7"); dat(8'h05, "R7");

        // R2: comma as the would-be closing character while armed
        req_lvl = 1; idle("R2"); req_lvl = 0;
        dat(8'h11, "R2"); dat(8'h22, "R2"); dat(8'h33, "R2"); com("R2");
        check(out_valid === 1'b0, "R2", "dropped word strobe", 32'(out_valid), 32'h0);
        dat(8'h44, "R2"); dat(8'h55, "R2"); dat(8'h66, "R2");

        idle("R1"); idle("R1");
        check(exp_q.size() == 0, "R1", "words outstanding", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule